// File: doc/BRIEF.md
# Memory Operation Ordering Buffer

This block keeps every in-flight load and store of a processor core in a circular queue that is ordered by program position. An entry is taken at issue time, before its address is known. Later the entry is filled in. A store receives its address and its data independently. A load receives its address and is then treated as executed. The policy is optimistic: a load whose address is known may go ahead even when older stores still have unknown addresses.

When a load resolves, the block searches the older stores that already know their address. The youngest such store with the same address wins. If its data is present, that data is forwarded. If it is not, the load receives the tag of the unit that will produce the data. If nothing matches, the load is cleared to access memory. When a store address resolves, the block searches the younger loads that have already executed. The oldest one with the same address is reported as a mis-speculation, so that the core can flush and restart from it.

Entries retire from the head, one per cycle, once complete. A flush input cuts the tail back to a given slot. The depth must be a power of two. A load address and a store address are never resolved in the same cycle.

Top module: `mem_order_buf`

## Requirements
- R1: After reset the queue is empty: `full` is 0, `alloc_idx` is 0, and no response, violation or retire pulse is asserted. An allocation request writes the slot shown on `alloc_idx`, and the tail then advances by one, modulo DEPTH. While DEPTH entries are live, `full` is 1 and allocation requests are ignored.
- R2: One cycle after a load resolves, `ld_resp_valid` pulses with the load's slot. If the youngest older store with a known, equal address already has data, `ld_resp_kind` is 1 and `ld_resp_data` carries that data.
- R3: If that youngest matching older store has no data yet, `ld_resp_kind` is 2 and `ld_resp_tag` carries the producer tag that was given when the store was allocated.
- R4: If no older store with a known address matches, `ld_resp_kind` is 0 (go to memory). Younger stores, and stores whose address is unknown, never match.
- R5: When several older stores match, the one nearest to the load in program order is used.
- R6: One cycle after a store address resolves, `viol_valid` pulses if a younger, executed load has the same address, and `viol_idx` gives the oldest such load.
- R7: Loads that have not yet resolved their address never cause a violation.
- R8: Each cycle without a flush, the head entry retires when it is complete. A store is complete once it has both its address and its data. A load is complete once it has resolved. `retire_valid` pulses one cycle later, with the slot and with `retire_is_store`. Retirement follows queue order.
- R9: A flush sets the tail to `flush_idx`, which must lie between the head and the tail. The entries from that slot onward are dropped, so `alloc_idx` equals `flush_idx` one cycle later. In the flush cycle, allocation and retirement do not happen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate one entry at the tail |
| alloc_is_store | input | 1 | Set when the new entry is a store |
| alloc_tag | input | TAG_W | Producer tag for the store's data |
| alloc_idx | output | IDX_W | Slot that the next allocation takes |
| full | output | 1 | All DEPTH slots are live |
| st_addr_valid | input | 1 | A store address resolves |
| st_addr_idx | input | IDX_W | Slot of that store |
| st_addr | input | ADDR_W | Resolved store address |
| st_data_valid | input | 1 | Store data arrives |
| st_data_idx | input | IDX_W | Slot of that store |
| st_data | input | DATA_W | Store data |
| ld_addr_valid | input | 1 | A load address resolves |
| ld_addr_idx | input | IDX_W | Slot of that load |
| ld_addr | input | ADDR_W | Resolved load address |
| flush_valid | input | 1 | Truncate the tail |
| flush_idx | input | IDX_W | First slot that is dropped |
| ld_resp_valid | output | 1 | Load search result is valid |
| ld_resp_idx | output | IDX_W | Load that was searched |
| ld_resp_kind | output | 2 | 0 memory, 1 forward, 2 tag |
| ld_resp_data | output | DATA_W | Forwarded data |
| ld_resp_tag | output | TAG_W | Producer tag to wait on |
| viol_valid | output | 1 | Mis-speculated load found |
| viol_idx | output | IDX_W | Oldest offending load |
| retire_valid | output | 1 | Head entry retired |
| retire_idx | output | IDX_W | Slot retired |
| retire_is_store | output | 1 | Retired entry was a store |

## Verification
The hardest case to reach is a violation. It needs a load to execute while an older store to the same address still has an unknown address, and only then the store resolves. Another variant has an unexecuted younger load sitting between the store and the offender. The stimulus narrows addresses to four values and resolves random live entries in random order. The queue stays near full, because retirement waits on completion. This produces stores resolving late behind executed loads, as well as several matching stores ahead of one load. Occasional flushes to random live slots exercise tail truncation across the wrap point.

// File: rtl/mob_pkg.sv
package mob_pkg;
  typedef enum logic [1:0] {
    RESP_MEM = 2'd0,
    RESP_FWD = 2'd1,
    RESP_TAG = 2'd2
  } resp_kind_t;
endpackage

// File: rtl/mob_ptrs.sv
module mob_ptrs #(
  parameter int DEPTH = 8,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_ok,
  input  logic             retire_ok,
  input  logic             flush_valid,
  input  logic [IDX_W-1:0] flush_idx,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic [IDX_W:0]   count,
  output logic             full
);
  logic [IDX_W:0] head_q, tail_q;
  logic           flush_wrap;

  assign head_idx   = head_q[IDX_W-1:0];
  assign tail_idx   = tail_q[IDX_W-1:0];
  assign count      = tail_q - head_q;
  assign full       = (count == (IDX_W+1)'(DEPTH));
  // slots at or above the head index share its lap; lower ones are one lap on
  assign flush_wrap = (flush_idx >= head_idx) ? head_q[IDX_W] : ~head_q[IDX_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (retire_ok) head_q <= head_q + 1'b1;
      if (flush_valid)   tail_q <= {flush_wrap, flush_idx};
      else if (alloc_ok) tail_q <= tail_q + 1'b1;
    end
  end

  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= (IDX_W+1)'(DEPTH));
  // R9
  flush_trunc_chk: assert property (@(posedge clk) disable iff (rst)
    flush_valid |=> tail_idx == $past(flush_idx));
endmodule

// File: rtl/mob_pick.sv
module mob_pick #(
  parameter int DEPTH    = 8,
  parameter int IDX_W    = $clog2(DEPTH),
  parameter bit YOUNGEST = 1'b1
) (
  input  logic [IDX_W-1:0] head_idx,
  input  logic [DEPTH-1:0] match,
  output logic             found,
  output logic [IDX_W-1:0] sel
);
  logic [IDX_W-1:0] age [DEPTH];
  logic [DEPTH-1:0] better;
  logic [IDX_W-1:0] best_age;

  for (genvar g = 0; g < DEPTH; g++) begin : g_age
    assign age[g] = IDX_W'(g) - head_idx;
  end

  always_comb begin
    found    = 1'b0;
    sel      = '0;
    best_age = '0;
    better   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (YOUNGEST) better[i] = age[i] > best_age;
      else          better[i] = age[i] < best_age;
      if (match[i] && (!found || better[i])) begin
        found    = 1'b1;
        sel      = IDX_W'(i);
        best_age = age[i];
      end
    end
  end
endmodule

// File: rtl/mem_order_buf.sv
module mem_order_buf #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 4,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_valid,
  input  logic              alloc_is_store,
  input  logic [TAG_W-1:0]  alloc_tag,
  output logic [IDX_W-1:0]  alloc_idx,
  output logic              full,
  input  logic              st_addr_valid,
  input  logic [IDX_W-1:0]  st_addr_idx,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              st_data_valid,
  input  logic [IDX_W-1:0]  st_data_idx,
  input  logic [DATA_W-1:0] st_data,
  input  logic              ld_addr_valid,
  input  logic [IDX_W-1:0]  ld_addr_idx,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              flush_valid,
  input  logic [IDX_W-1:0]  flush_idx,
  output logic              ld_resp_valid,
  output logic [IDX_W-1:0]  ld_resp_idx,
  output logic [1:0]        ld_resp_kind,
  output logic [DATA_W-1:0] ld_resp_data,
  output logic [TAG_W-1:0]  ld_resp_tag,
  output logic              viol_valid,
  output logic [IDX_W-1:0]  viol_idx,
  output logic              retire_valid,
  output logic [IDX_W-1:0]  retire_idx,
  output logic              retire_is_store
);
  import mob_pkg::*;

  logic [IDX_W-1:0]  head_idx, tail_idx;
  logic [IDX_W:0]    count;
  logic              alloc_ok, retire_ok, head_done;

  logic [DEPTH-1:0]  e_store, e_aok, e_dok, e_exec;
  logic [ADDR_W-1:0] e_addr [DEPTH];
  logic [DATA_W-1:0] e_data [DEPTH];
  logic [TAG_W-1:0]  e_tag  [DEPTH];

  logic [DEPTH-1:0]  older_st, young_ld;
  logic [IDX_W-1:0]  ld_age, st_age, f_sel, v_sel;
  logic              f_found, v_found;
  resp_kind_t        kind_d;

  assign alloc_idx = tail_idx;
  assign alloc_ok  = alloc_valid && !full && !flush_valid;
  assign head_done = e_store[head_idx] ? (e_aok[head_idx] && e_dok[head_idx])
                                       : e_exec[head_idx];
  assign retire_ok = (count != '0) && head_done && !flush_valid;

  mob_ptrs #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ptrs (
    .clk(clk), .rst(rst), .alloc_ok(alloc_ok), .retire_ok(retire_ok),
    .flush_valid(flush_valid), .flush_idx(flush_idx),
    .head_idx(head_idx), .tail_idx(tail_idx), .count(count), .full(full));

  // entry flags
  always_ff @(posedge clk) begin
    if (rst) begin
      e_store <= '0;
      e_aok   <= '0;
      e_dok   <= '0;
      e_exec  <= '0;
    end else begin
      if (alloc_ok) begin
        e_store[tail_idx] <= alloc_is_store;
        e_aok[tail_idx]   <= 1'b0;
        e_dok[tail_idx]   <= 1'b0;
        e_exec[tail_idx]  <= 1'b0;
      end
      if (st_addr_valid) e_aok[st_addr_idx] <= 1'b1;
      if (st_data_valid) e_dok[st_data_idx] <= 1'b1;
      if (ld_addr_valid) begin
        e_aok[ld_addr_idx]  <= 1'b1;
        e_exec[ld_addr_idx] <= 1'b1;
      end
    end
  end

  // entry payload, no reset
  always_ff @(posedge clk) begin
    if (alloc_ok)      e_tag[tail_idx]     <= alloc_tag;
    if (st_addr_valid) e_addr[st_addr_idx] <= st_addr;
    if (ld_addr_valid) e_addr[ld_addr_idx] <= ld_addr;
    if (st_data_valid) e_data[st_data_idx] <= st_data;
  end

  // associative match vectors by age relative to head
  assign ld_age = ld_addr_idx - head_idx;
  assign st_age = st_addr_idx - head_idx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic [IDX_W-1:0] age;
    assign age         = IDX_W'(g) - head_idx;
    assign older_st[g] = e_store[g] && e_aok[g] && (e_addr[g] == ld_addr) && (age < ld_age);
    assign young_ld[g] = !e_store[g] && e_exec[g] && (e_addr[g] == st_addr) &&
                         (age > st_age) && ({1'b0, age} < count);
  end

  mob_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W), .YOUNGEST(1'b1)) u_fwd_pick (
    .head_idx(head_idx), .match(older_st), .found(f_found), .sel(f_sel));

  mob_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W), .YOUNGEST(1'b0)) u_viol_pick (
    .head_idx(head_idx), .match(young_ld), .found(v_found), .sel(v_sel));

  always_comb begin
    if (!f_found)          kind_d = RESP_MEM;
    else if (e_dok[f_sel]) kind_d = RESP_FWD;
    else                   kind_d = RESP_TAG;
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      ld_resp_valid   <= 1'b0;
      ld_resp_idx     <= '0;
      ld_resp_kind    <= 2'd0;
      ld_resp_data    <= '0;
      ld_resp_tag     <= '0;
      viol_valid      <= 1'b0;
      viol_idx        <= '0;
      retire_valid    <= 1'b0;
      retire_idx      <= '0;
      retire_is_store <= 1'b0;
    end else begin
      ld_resp_valid   <= ld_addr_valid;
      ld_resp_idx     <= ld_addr_idx;
      ld_resp_kind    <= kind_d;
      ld_resp_data    <= e_data[f_sel];
      ld_resp_tag     <= e_tag[f_sel];
      viol_valid      <= st_addr_valid && v_found;
      viol_idx        <= v_sel;
      retire_valid    <= retire_ok;
      retire_idx      <= head_idx;
      retire_is_store <= e_store[head_idx];
    end
  end

  // R1
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    full && alloc_valid && !flush_valid |=> $stable(alloc_idx));
  // R2
  resp_cause_chk: assert property (@(posedge clk) disable iff (rst)
    ld_resp_valid |-> $past(ld_addr_valid));
  // R6
  viol_cause_chk: assert property (@(posedge clk) disable iff (rst)
    viol_valid |-> $past(st_addr_valid));
  // R6
  single_resolve_chk: assert property (@(posedge clk) disable iff (rst)
    !(st_addr_valid && ld_addr_valid));
  // R8
  retire_order_chk: assert property (@(posedge clk) disable iff (rst)
    retire_valid && $past(retire_valid) |-> retire_idx == IDX_W'($past(retire_idx) + 1'b1));
endmodule

// File: tb/test_mem_order_buf.sv
module test_mem_order_buf;
  localparam int D = 8;
  localparam int IW = 3;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int TW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          alloc_valid = 0, alloc_is_store = 0;
  logic [TW-1:0] alloc_tag = '0;
  logic [IW-1:0] alloc_idx;
  logic          full;
  logic          st_addr_valid = 0, st_data_valid = 0, ld_addr_valid = 0, flush_valid = 0;
  logic [IW-1:0] st_addr_idx = '0, st_data_idx = '0, ld_addr_idx = '0, flush_idx = '0;
  logic [AW-1:0] st_addr = '0, ld_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic          ld_resp_valid, viol_valid, retire_valid, retire_is_store;
  logic [IW-1:0] ld_resp_idx, viol_idx, retire_idx;
  logic [1:0]    ld_resp_kind;
  logic [DW-1:0] ld_resp_data;
  logic [TW-1:0] ld_resp_tag;

  mem_order_buf #(.DEPTH(D), .ADDR_W(AW), .DATA_W(DW), .TAG_W(TW)) i_mem_order_buf (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_is_store(alloc_is_store),
    .alloc_tag(alloc_tag), .alloc_idx(alloc_idx), .full(full),
    .st_addr_valid(st_addr_valid), .st_addr_idx(st_addr_idx), .st_addr(st_addr),
    .st_data_valid(st_data_valid), .st_data_idx(st_data_idx), .st_data(st_data),
    .ld_addr_valid(ld_addr_valid), .ld_addr_idx(ld_addr_idx), .ld_addr(ld_addr),
    .flush_valid(flush_valid), .flush_idx(flush_idx),
    .ld_resp_valid(ld_resp_valid), .ld_resp_idx(ld_resp_idx), .ld_resp_kind(ld_resp_kind),
    .ld_resp_data(ld_resp_data), .ld_resp_tag(ld_resp_tag),
    .viol_valid(viol_valid), .viol_idx(viol_idx),
    .retire_valid(retire_valid), .retire_idx(retire_idx), .retire_is_store(retire_is_store));

  // reference model state
  int m_head, m_cnt;
  bit m_st [D], m_aok [D], m_dok [D], m_exec [D];
  int m_addr [D], m_data [D], m_tag [D];
  // expected outputs
  bit x_lv, x_vv, x_rv, x_rs, x_flushed;
  int x_li, x_lk, x_ld, x_lt, x_vi, x_ri;
  string x_lreq, x_vreq;

  int checks = 0, fails = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_head = 0; m_cnt = 0;
      x_lv = 0; x_vv = 0; x_rv = 0; x_flushed = 0;
      for (int i = 0; i < D; i++) begin
        m_st[i] = 0; m_aok[i] = 0; m_dok[i] = 0; m_exec[i] = 0;
      end
    end else begin
      int h0, c0, best, nm, la, sa;
      bit skipped;
      h0 = m_head; c0 = m_cnt;
      x_lv = 0; x_vv = 0; x_rv = 0; x_flushed = flush_valid;
      if (ld_addr_valid) begin
        la = (int'(ld_addr_idx) - h0 + D) % D;
        best = -1; nm = 0;
        for (int a = 0; a < la; a++) begin
          int e;
          e = (h0 + a) % D;
          if (m_st[e] && m_aok[e] && m_addr[e] == int'(ld_addr)) begin best = e; nm++; end
        end
        x_lv = 1; x_li = ld_addr_idx;
        if (best < 0) begin x_lk = 0; x_lreq = "R4"; end
        else if (m_dok[best]) begin x_lk = 1; x_ld = m_data[best]; x_lreq = "R2"; end
        else begin x_lk = 2; x_lt = m_tag[best]; x_lreq = "R3"; end
        if (nm > 1) x_lreq = "R5";
      end
      if (st_addr_valid) begin
        sa = (int'(st_addr_idx) - h0 + D) % D;
        best = -1; skipped = 0;
        for (int a = c0 - 1; a > sa; a--) begin
          int e;
          e = (h0 + a) % D;
          if (!m_st[e] && m_exec[e] && m_addr[e] == int'(st_addr)) best = e;
          else if (!m_st[e] && !m_exec[e]) skipped = 1;
        end
        x_vv = (best >= 0); x_vi = best;
        x_vreq = skipped ? "R7" : "R6";
      end
      if (!flush_valid && c0 > 0 &&
          (m_st[h0] ? (m_aok[h0] && m_dok[h0]) : m_exec[h0])) begin
        x_rv = 1; x_ri = h0; x_rs = m_st[h0];
        m_head = (h0 + 1) % D; m_cnt = m_cnt - 1;
      end
      if (st_addr_valid) begin m_aok[st_addr_idx] = 1; m_addr[st_addr_idx] = int'(st_addr); end
      if (st_data_valid) begin m_dok[st_data_idx] = 1; m_data[st_data_idx] = int'(st_data); end
      if (ld_addr_valid) begin
        m_aok[ld_addr_idx] = 1; m_exec[ld_addr_idx] = 1; m_addr[ld_addr_idx] = int'(ld_addr);
      end
      if (flush_valid) m_cnt = (int'(flush_idx) - h0 + D) % D;
      else if (alloc_valid && c0 < D) begin
        int t;
        t = (h0 + c0) % D;
        m_st[t] = alloc_is_store; m_aok[t] = 0; m_dok[t] = 0; m_exec[t] = 0;
        m_tag[t] = int'(alloc_tag);
        m_cnt = m_cnt + 1;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    string rq;
    rq = x_flushed ? "R9" : "R1";
    chk(rq, "alloc_idx", int'(alloc_idx), (m_head + m_cnt) % D);
    chk("R1", "full", int'(full), int'(m_cnt == D));
    chk(x_lv ? x_lreq : "R2", "ld_resp_valid", int'(ld_resp_valid), int'(x_lv));
    if (x_lv && ld_resp_valid) begin
      chk(x_lreq, "ld_resp_idx", int'(ld_resp_idx), x_li);
      chk(x_lreq, "ld_resp_kind", int'(ld_resp_kind), x_lk);
      if (x_lk == 1) chk(x_lreq, "ld_resp_data", int'(ld_resp_data), x_ld);
      if (x_lk == 2) chk(x_lreq, "ld_resp_tag", int'(ld_resp_tag), x_lt);
    end
    chk(x_vreq, "viol_valid", int'(viol_valid), int'(x_vv));
    if (x_vv && viol_valid) chk(x_vreq, "viol_idx", int'(viol_idx), x_vi);
    chk("R8", "retire_valid", int'(retire_valid), int'(x_rv));
    if (x_rv && retire_valid) begin
      chk("R8", "retire_idx", int'(retire_idx), x_ri);
      chk("R8", "retire_is_store", int'(retire_is_store), int'(x_rs));
    end
  endtask

  initial begin
    x_vreq = "R6"; x_lreq = "R2";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int cyc = 0; cyc < 6000; cyc++) begin
      @(negedge clk);
      compare_all();
      alloc_valid = 0; st_addr_valid = 0; st_data_valid = 0; ld_addr_valid = 0; flush_valid = 0;
      if (($urandom % 50) == 0) begin
        flush_valid = 1;
        flush_idx = IW'((m_head + int'($urandom % (m_cnt + 1))) % D);
      end else begin
        alloc_valid = ($urandom % 2) == 0;
        alloc_is_store = ($urandom % 2) == 0;
        alloc_tag = TW'($urandom);
        if (m_cnt > 0 && ($urandom % 4) != 0) begin
          int e;
          e = (m_head + int'($urandom % m_cnt)) % D;
          if (m_st[e] && !m_aok[e] && (m_dok[e] || ($urandom % 2) == 0)) begin
            st_addr_valid = 1; st_addr_idx = IW'(e); st_addr = AW'($urandom % 4);
          end else if (m_st[e] && !m_dok[e]) begin
            st_data_valid = 1; st_data_idx = IW'(e); st_data = DW'($urandom);
          end else if (!m_st[e] && !m_exec[e]) begin
            ld_addr_valid = 1; ld_addr_idx = IW'(e); ld_addr = AW'($urandom % 4);
          end
        end
      end
    end
    @(negedge clk);
    compare_all();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < 150000; k++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule